// File: doc/BRIEF.md
# Pixel Color Processor with Banked Lookup Table

This block turns a stream of 32-bit words from video memory into 24-bit RGB pixels. The words arrive on a valid/ready handshake and are treated as one continuous bit stream, most significant bit first. The block hands out one pixel for each pixel request strobe, provided enough bits are buffered. How many bits a pixel takes, and how they become red, green and blue, depends on a three-bit color mode: direct 32-bit, packed 24-bit, 5-6-5 16-bit, 8-bit gray, or 8-bit indexed.

Indexed pixels pass through an internal color table. The table has two banks of 256 entries of 24 bits each. A host write port fills either bank at any time. Pixel lookups use only the active bank. A request to swap banks is held until the next vertical retrace strobe, and the swap happens there, so a frame never shows a mix of two palettes.

Every mode has the same two-cycle latency from request to pixel, so display timing does not depend on the mode.

Top module: `pix_color_proc`

## Requirements
- R1: During and directly after reset, `pix_valid` is 0, `active_bank` is 0 and `word_ready` is 1.
- R2: `word_ready` is 1 exactly when at most 32 unconsumed bits are buffered. A word is taken only when `word_valid` and `word_ready` are both high. Taken words are appended to the bit stream most significant bit first.
- R3: A request sampled with at least one pixel's width of bits buffered yields `pix_valid` two clock edges later. A request with fewer bits buffered yields no pixel and consumes nothing. The widths are 32 bits for mode 0, 24 for mode 1, 16 for mode 2 and 8 for modes 3 and 4.
- R4: Mode 0 (32-bit) takes a whole word. The pixel is bits 23:0, with red in bits 23:16, and the top byte is ignored.
- R5: Mode 1 (24-bit) takes 24-bit fields in stream order, so four pixels span three words. The first bits of a field are red.
- R6: Mode 2 (16-bit) reads red from field bits 15:11, green from 10:5 and blue from 4:0. Each channel is widened to 8 bits by repeating its top bits below it.
- R7: Mode 3 (gray) copies the 8-bit value to all three channels.
- R8: Mode 4 (indexed) outputs the table entry that the 8-bit index selects in the active bank. A host write to that same entry in the same cycle as the lookup read does not affect the read, which returns the old contents.
- R9: A host write stores the data at the chosen bank and address, whether or not that bank is active.
- R10: `bank_sw_req` is held until a `vretrace` cycle, and `active_bank` toggles only on that edge. `vretrace` with no request held or present leaves the bank unchanged. A request in the same cycle as `vretrace` toggles the bank at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Memory word offered |
| word_data | input | 32 | Memory word |
| word_ready | output | 1 | Block can take a word |
| pix_req | input | 1 | Pixel request strobe |
| mode | input | 3 | Color mode: 0 32-bit, 1 24-bit, 2 16-bit, 3 gray, 4 indexed |
| clut_wr_en | input | 1 | Table write strobe |
| clut_wr_bank | input | 1 | Bank written |
| clut_wr_addr | input | 8 | Entry written |
| clut_wr_data | input | 24 | RGB data written |
| bank_sw_req | input | 1 | Request a bank swap at the next retrace |
| vretrace | input | 1 | Vertical retrace strobe |
| active_bank | output | 1 | Bank used for lookups |
| pix_valid | output | 1 | Pixel present |
| pix_rgb | output | 24 | Pixel, red in 23:16, blue in 7:0 |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a lookup read and a host write to the same table entry. To force it, the bench feeds a stream of words that all hold index 0x55 and rewrites entry 0x55 of the active bank every cycle with new data. The reference model takes the lookup from its table as it stood before that edge, so a pixel carrying the fresh data is flagged.

The second pair is a swap request and a retrace strobe. The bench pulses both in the same cycle, and also pulses retrace with no request pending. `active_bank` and the bank used by every following indexed pixel are compared with the model on every cycle.

// File: rtl/pcp_pkg.sv
// Shared constants, mode codes and per-mode pixel width for the color processor.
// Assumes 32-bit memory words and 8-bit color channels.
package pcp_pkg;
    localparam int WORD_W  = 32;
    localparam int CH_W    = 8;
    localparam int RGB_W   = 3 * CH_W;
    localparam int IDX_W   = 8;
    localparam int BANKS   = 2;
    localparam int BANK_W  = $clog2(BANKS);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int BUF_W   = 2 * WORD_W;
    localparam int CNT_W   = $clog2(BUF_W + 1);
    localparam int MODE_W  = 3;

    localparam logic [MODE_W-1:0] MODE_RGB32 = 3'd0;
    localparam logic [MODE_W-1:0] MODE_RGB24 = 3'd1;
    localparam logic [MODE_W-1:0] MODE_RGB16 = 3'd2;
    localparam logic [MODE_W-1:0] MODE_GRAY8 = 3'd3;
    localparam logic [MODE_W-1:0] MODE_IDX8  = 3'd4;

    // Bits consumed by one pixel in a given mode; unused codes act as 32-bit.
    function automatic logic [CNT_W-1:0] pix_bits(input logic [MODE_W-1:0] m);
        case (m)
            MODE_RGB24: pix_bits = CNT_W'(24);
            MODE_RGB16: pix_bits = CNT_W'(16);
            MODE_GRAY8,
            MODE_IDX8:  pix_bits = CNT_W'(8);
            default:    pix_bits = CNT_W'(WORD_W);
        endcase
    endfunction
endpackage

// File: rtl/pcp_unpack.sv
// Bit-stream unpacker. Holds up to two memory words as one left-aligned
// bit queue and pulls a pixel field of the mode's width off the top.
// Assumes the mode is the same on both sides of a request (it is sampled
// in the same cycle). Consumption is seen before a new word is appended.
module pcp_unpack
    import pcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              pix_req,
    input  logic [MODE_W-1:0] mode,
    output logic              pix_take,
    output logic [WORD_W-1:0] pix_raw
);
    logic [BUF_W-1:0] sbuf;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] cnt_mid;
    logic [BUF_W-1:0] sbuf_mid;
    logic             accept;

    // Room for a whole word means the buffered bits fit in the low half.
    assign word_ready = (cnt <= CNT_W'(WORD_W));
    assign accept     = word_valid && word_ready;
    assign width      = pix_bits(mode);
    assign pix_take   = pix_req && (cnt >= width);
    assign pix_raw    = sbuf[BUF_W-1 -: WORD_W];

    // Remove the consumed field before appending the incoming word.
    always_comb begin
        cnt_mid  = pix_take ? (cnt - width) : cnt;
        sbuf_mid = pix_take ? (sbuf << width) : sbuf;
    end

    // Bit queue update: shift out the field, splice the word below the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbuf <= '0;
            cnt  <= '0;
        end else begin
            if (accept) begin
                sbuf <= sbuf_mid | ({word_data, {WORD_W{1'b0}}} >> cnt_mid);
                cnt  <= cnt_mid + CNT_W'(WORD_W);
            end else begin
                sbuf <= sbuf_mid;
                cnt  <= cnt_mid;
            end
        end
    end

    // R2: a word taken with no pixel taken grows the queue by one word.
    assert_word_append_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pix_take) |=> (cnt == $past(cnt) + CNT_W'(WORD_W)));

    // R3: a request that finds too few bits leaves the queue untouched.
    assert_short_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_take && !word_valid) |=> $stable(cnt) && $stable(sbuf));

    // R2: the queue never exceeds its two-word capacity.
    assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BUF_W));
endmodule

// File: rtl/pcp_direct.sv
// Direct color conversion for the non-indexed modes. The field is
// left-aligned in raw. Also flags the indexed mode, whose color comes
// from the table instead. Purely combinational.
module pcp_direct
    import pcp_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [WORD_W-1:0] raw,
    output logic [RGB_W-1:0]  rgb,
    output logic              use_lut
);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;
    logic [CH_W-1:0] top8;

    assign r5   = raw[WORD_W-1 -: 5];
    assign g6   = raw[WORD_W-6 -: 6];
    assign b5   = raw[WORD_W-12 -: 5];
    assign top8 = raw[WORD_W-1 -: CH_W];

    // Per-mode channel build; 5-6-5 channels are widened by bit repetition.
    always_comb begin
        use_lut = 1'b0;
        case (mode)
            MODE_RGB24: rgb = raw[WORD_W-1 -: RGB_W];
            MODE_RGB16: rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
            MODE_GRAY8: rgb = {top8, top8, top8};
            MODE_IDX8: begin
                rgb     = '0;
                use_lut = 1'b1;
            end
            default:    rgb = raw[RGB_W-1:0];
        endcase
    end
endmodule

// File: rtl/pcp_clut.sv
// Banked color table. One memory per bank, each read every cycle with a
// registered output. A registered bank select picks the result. Host writes go
// to any bank. A read and a write to the same entry in one cycle return the old
// data. The active bank changes only on a retrace strobe when a swap request
// is pending or arrives in that same cycle. The memories are not reset.
module pcp_clut
    import pcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [RGB_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              sw_req,
    input  logic              vretrace,
    output logic [BANK_W-1:0] active_bank,
    output logic [RGB_W-1:0]  rd_data
);
    logic [BANKS-1:0][RGB_W-1:0] bank_q;
    logic [BANK_W-1:0]           sel_r;
    logic                        pending;
    logic                        do_swap;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [RGB_W-1:0] mem [DEPTH];
        logic [RGB_W-1:0] q_r;

        // Bank storage: write when selected, read the index every cycle.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BANK_W'(b))) begin
                mem[wr_addr] <= wr_data;
            end
            q_r <= mem[rd_idx];
        end

        assign bank_q[b] = q_r;
    end

    assign do_swap = vretrace && (pending || sw_req);
    assign rd_data = bank_q[sel_r];

    // Bank control: hold the request, toggle at retrace, track read bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending     <= 1'b0;
            active_bank <= '0;
            sel_r       <= '0;
        end else begin
            sel_r <= active_bank;
            if (do_swap) begin
                active_bank <= active_bank + BANK_W'(1);
                pending     <= 1'b0;
            end else if (sw_req) begin
                pending <= 1'b1;
            end
        end
    end

    // R10: outside retrace the active bank holds.
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vretrace |=> $stable(active_bank));

    // R10: a swap requested now or earlier takes effect at the retrace edge.
    assert_bank_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vretrace && sw_req) |=> (active_bank != $past(active_bank)));

    // R10: after a swap no request stays pending.
    assert_swap_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vretrace && !sw_req) |=> !pending);
endmodule

// File: rtl/pix_color_proc.sv
// Pixel color processor top. Unpacks the word stream into fields (stage 1)
// and converts them, direct or through the color table (stage 2). Every
// mode sees the same two-edge latency from request to pixel. Assumes a
// two-bank table, so the bank ports are one bit wide.
module pix_color_proc
    import pcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              pix_req,
    input  logic [MODE_W-1:0] mode,
    input  logic              clut_wr_en,
    input  logic              clut_wr_bank,
    input  logic [IDX_W-1:0]  clut_wr_addr,
    input  logic [RGB_W-1:0]  clut_wr_data,
    input  logic              bank_sw_req,
    input  logic              vretrace,
    output logic              active_bank,
    output logic              pix_valid,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic              take;
    logic [WORD_W-1:0] raw;
    logic              s1_valid;
    logic [MODE_W-1:0] s1_mode;
    logic [WORD_W-1:0] s1_raw;
    logic [RGB_W-1:0]  dir_rgb;
    logic              dir_lut;
    logic              s2_valid;
    logic [RGB_W-1:0]  s2_rgb;
    logic              s2_lut;
    logic [RGB_W-1:0]  lut_q;

    pcp_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .pix_req    (pix_req),
        .mode       (mode),
        .pix_take   (take),
        .pix_raw    (raw)
    );

    // Stage 1: capture the extracted field and its mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= MODE_RGB32;
            s1_raw   <= '0;
        end else begin
            s1_valid <= take;
            if (take) begin
                s1_mode <= mode;
                s1_raw  <= raw;
            end
        end
    end

    pcp_direct u_direct (
        .mode    (s1_mode),
        .raw     (s1_raw),
        .rgb     (dir_rgb),
        .use_lut (dir_lut)
    );

    pcp_clut u_clut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (clut_wr_en),
        .wr_bank     (clut_wr_bank),
        .wr_addr     (clut_wr_addr),
        .wr_data     (clut_wr_data),
        .rd_idx      (s1_raw[WORD_W-1 -: IDX_W]),
        .sw_req      (bank_sw_req),
        .vretrace    (vretrace),
        .active_bank (active_bank),
        .rd_data     (lut_q)
    );

    // Stage 2: register direct colors alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_rgb   <= '0;
            s2_lut   <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            s2_rgb   <= dir_rgb;
            s2_lut   <= dir_lut;
        end
    end

    assign pix_valid = s2_valid;
    assign pix_rgb   = s2_lut ? lut_q : s2_rgb;

    // R3: every pixel traces back to a request two edges earlier.
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pix_req, 2));

    // R7: gray pixels carry one value on all channels.
    assert_gray_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(mode, 2) == MODE_GRAY8) |->
        (pix_rgb[23:16] == pix_rgb[15:8]) && (pix_rgb[15:8] == pix_rgb[7:0]));

    // R6: widened red repeats its top three bits in its low three bits.
    assert_rep565_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(mode, 2) == MODE_RGB16) |->
        (pix_rgb[18:16] == pix_rgb[23:21]) && (pix_rgb[9:8] == pix_rgb[15:14]));
endmodule

// File: tb/pix_color_proc_bench.sv
// Self-checking bench: behavioural reference model (bit queue, table
// array, two-entry pipeline) compared with the ports on every clock.
module pix_color_proc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        pix_req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        clut_wr_en = 1'b0;
    logic        clut_wr_bank = 1'b0;
    logic [7:0]  clut_wr_addr = '0;
    logic [23:0] clut_wr_data = '0;
    logic        bank_sw_req = 1'b0;
    logic        vretrace = 1'b0;
    logic        active_bank;
    logic        pix_valid;
    logic [23:0] pix_rgb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pix_color_proc u_pix_color_proc (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .pix_req(pix_req), .mode(mode),
        .clut_wr_en(clut_wr_en), .clut_wr_bank(clut_wr_bank),
        .clut_wr_addr(clut_wr_addr), .clut_wr_data(clut_wr_data),
        .bank_sw_req(bank_sw_req), .vretrace(vretrace),
        .active_bank(active_bank), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
    );

    // Reference model state
    bit          mq[$];
    bit          m_s1v, m_s2v;
    logic [2:0]  m_s1mode, m_s2mode;
    logic [31:0] m_s1raw;
    logic [23:0] m_s2rgb;
    bit          m_bank, m_pend;
    logic [23:0] m_lut [2][256];

    function automatic int field_bits(input logic [2:0] m);
        if (m == 3'd1) return 24;
        if (m == 3'd2) return 16;
        if (m == 3'd3 || m == 3'd4) return 8;
        return 32;
    endfunction

    function automatic logic [23:0] model_rgb(input logic [2:0] m, input logic [31:0] f);
        int r, g, b;
        case (m)
            3'd0: return f[23:0];
            3'd1: return f[31:8];
            3'd2: begin
                r = int'(f[31:27]); g = int'(f[26:21]); b = int'(f[20:16]);
                r = r * 8 + r / 4;  g = g * 4 + g / 16; b = b * 8 + b / 4;
                return {r[7:0], g[7:0], b[7:0]};
            end
            3'd3: return {f[31:24], f[31:24], f[31:24]};
            default: return m_lut[m_bank][f[31:24]];
        endcase
    endfunction

    // Model step on each edge, in the order the requirements define.
    always @(posedge clk) begin
        int  w;
        bit  room;
        logic [31:0] f;
        if (!rst_n) begin
            mq.delete();
            m_s1v = 0; m_s2v = 0; m_bank = 0; m_pend = 0;
        end else begin
            if (m_s1v) begin
                m_s2rgb  = model_rgb(m_s1mode, m_s1raw);
                m_s2mode = m_s1mode;
            end
            m_s2v = m_s1v;
            room = (mq.size() <= 32);
            w = field_bits(mode);
            if (pix_req && mq.size() >= w) begin
                f = '0;
                for (int i = 0; i < w; i++) f[31-i] = mq.pop_front();
                m_s1v = 1; m_s1mode = mode; m_s1raw = f;
            end else begin
                m_s1v = 0;
            end
            if (word_valid && room)
                for (int i = 31; i >= 0; i--) mq.push_back(word_data[i]);
            if (clut_wr_en) m_lut[clut_wr_bank][clut_wr_addr] = clut_wr_data;
            if (vretrace && (m_pend || bank_sw_req)) begin
                m_bank = !m_bank; m_pend = 0;
            end else if (bank_sw_req) begin
                m_pend = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tag;
        check(pix_valid === m_s2v, "R3 pix_valid", 32'(pix_valid), 32'(m_s2v));
        if (m_s2v) begin
            case (m_s2mode)
                3'd0: tag = "R4 rgb32";
                3'd1: tag = "R5 rgb24";
                3'd2: tag = "R6 rgb16";
                3'd3: tag = "R7 gray";
                default: tag = "R8 R9 indexed";
            endcase
            check(pix_rgb === m_s2rgb, tag, 32'(pix_rgb), 32'(m_s2rgb));
        end
        check(word_ready === (mq.size() <= 32), "R2 word_ready", 32'(word_ready), 32'(mq.size() <= 32));
        check(active_bank === m_bank, "R10 active_bank", 32'(active_bank), 32'(m_bank));
    endtask

    task automatic quiet();
        word_valid = 0; pix_req = 0; clut_wr_en = 0; bank_sw_req = 0; vretrace = 0;
    endtask

    // Random traffic; percentages for each strobe.
    task automatic run(input int n, input int pw, input int pr, input int plw,
                       input int psw, input int pvr, input bit mix, input bit fixed55);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare_all();
            if (mix && (c % 40 == 0)) mode = 3'($urandom_range(4));
            word_valid   = ($urandom_range(99) < pw);
            word_data    = fixed55 ? 32'h5555_5555 : $urandom;
            pix_req      = ($urandom_range(99) < pr);
            clut_wr_en   = fixed55 ? 1'b1 : ($urandom_range(99) < plw);
            clut_wr_bank = fixed55 ? m_bank : 1'($urandom_range(1));
            clut_wr_addr = fixed55 ? 8'h55 : 8'($urandom_range(255));
            clut_wr_data = 24'($urandom);
            bank_sw_req  = ($urandom_range(99) < psw);
            vretrace     = ($urandom_range(99) < pvr);
        end
    endtask

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(pix_valid === 1'b0, "R1 pix_valid in reset", 32'(pix_valid), 0);
        check(active_bank === 1'b0, "R1 active_bank in reset", 32'(active_bank), 0);
        check(word_ready === 1'b1, "R1 word_ready in reset", 32'(word_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_valid === 1'b0, "R1 pix_valid after reset", 32'(pix_valid), 0);
        // R9: fill both banks with distinct patterns
        for (int a = 0; a < 512; a++) begin
            compare_all();
            clut_wr_en = 1; clut_wr_bank = a[8];
            clut_wr_addr = a[7:0];
            clut_wr_data = a[8] ? {a[7:0], ~a[7:0], 8'h3c} : {8'hc3, a[7:0], a[7:0] ^ 8'h5a};
            @(negedge clk);
        end
        quiet();
        // Each mode alone, starved and saturated stream (R3, R4-R7)
        for (int m = 0; m < 4; m++) begin
            mode = 3'(m);
            run(600, 30, 90, 0, 0, 0, 0, 0);
            run(600, 90, 40, 0, 0, 0, 0, 0);
        end
        // Indexed with host writes, swaps and retraces (R8, R9, R10)
        mode = 3'd4;
        run(2000, 70, 70, 30, 5, 5, 0, 0);
        // R10 directed: retrace with nothing pending, then coincident request
        quiet(); @(negedge clk); compare_all();
        vretrace = 1; @(negedge clk); compare_all();
        vretrace = 0; bank_sw_req = 1; @(negedge clk); compare_all();
        bank_sw_req = 0; repeat (3) begin @(negedge clk); compare_all(); end
        vretrace = 1; @(negedge clk); compare_all();
        vretrace = 1; bank_sw_req = 1; @(negedge clk); compare_all();
        quiet(); @(negedge clk); compare_all();
        // R8 directed: lookups and writes hit entry 0x55 together
        run(300, 90, 90, 0, 0, 0, 0, 1);
        quiet();
        // Mixed modes across word boundaries
        run(4000, 60, 60, 10, 3, 3, 1, 0);
        quiet();
        repeat (4) begin @(negedge clk); compare_all(); end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R3 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule